// File: doc/BRIEF.md
# Decimal Time-of-Day Counter with Microsecond Alarm

This block holds one system-wide time-of-day value as a string of twenty 4-bit BCD digits. Digit 0 is the most significant digit and sits in bits [79:76]. Digit 19 sits in bits [3:0]. Digits 0–3 carry the year, 4–5 the month and 6–7 the day. Digit 8 is spare. The eleven digits 9–19 form a microsecond count, and that count advances by one on every cycle in which the one-microsecond tick strobe is high.

The hardware only ever advances the microsecond count. The calendar digits and the spare digit change only when software loads a complete new value, which it does at midnight. The whole register is visible at all times on the read output.

A second register holds an eleven-digit microsecond alarm value. A sticky interrupt flag sets when a tick finds the microsecond count equal to or above that alarm value. The flag stays set until software acknowledges it.

Top module: `tod_alarm_timer`

## Requirements
- R1: While reset is asserted and after it is released, the time output is all zero and the alarm interrupt is low.
- R2: A load (set_i high) writes all 80 bits of set_val_i into the register. The new value appears on tod_o after that clock edge.
- R3: On a clock edge with tick_i high and set_i low, the microsecond field tod_o[43:0] increases by one in decimal. Digit 19 is bits [3:0].
- R4: A digit that holds 9 when it receives a carry becomes 0 and passes the carry to the next more significant digit. A run of nines therefore ripples in a single tick.
- R5: If the microsecond field holds 99999999999, a tick wraps it to 00000000000.
- R6: Digits 0–8 (tod_o[79:44]) change only through a load. Ticks never change them, and neither does a microsecond wrap.
- R7: When set_i and tick_i are high on the same edge, the loaded value is taken as it is and is not incremented.
- R8: When set_i and tick_i are both low, tod_o holds its value.
- R9: alarm_ld_i writes alarm_val_i (eleven BCD digits) into the alarm register. The alarm register resets to zero.
- R10: On an edge with tick_i high, the interrupt sets if the pre-edge microsecond field is greater than or equal to the pre-edge alarm value. The equal case sets it. A smaller value leaves it unchanged.
- R11: alarm_irq_o stays high until alarm_ack_i. An acknowledge clears it on the next edge, and it wins over a set condition in the same cycle. Without a tick, the flag cannot rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-microsecond advance strobe |
| set_i | input | 1 | Load the full time value |
| set_val_i | input | 80 | Time value to load, 20 BCD digits, digit 0 in the top bits |
| tod_o | output | 80 | Current time value |
| alarm_ld_i | input | 1 | Load the alarm value |
| alarm_val_i | input | 44 | Alarm microsecond value, 11 BCD digits |
| alarm_irq_o | output | 1 | Sticky alarm interrupt |
| alarm_ack_i | input | 1 | Clear the alarm interrupt |

## Verification
Two pairs of events can land on the same clock edge, and each pair is forced by directed stimulus. A load can coincide with a tick: the bench drives both in one cycle, and the load must appear unincremented. An acknowledge can coincide with a tick whose compare holds: the flag must read low after that edge and rise again on the following tick. Random traffic then mixes ticks, loads, alarm writes and acknowledges at independent rates. After every edge a bench model built from decimal arithmetic judges the result.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned DIGIT_W     = 4;
  localparam int unsigned TOD_DIGITS  = 20;
  localparam int unsigned US_DIGITS   = 11;
  localparam int unsigned TOD_W       = DIGIT_W * TOD_DIGITS;
  localparam int unsigned US_W        = DIGIT_W * US_DIGITS;

  typedef logic [DIGIT_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcd_digit_inc.sv
module bcd_digit_inc
  import tod_pkg::*;
(
  input  bcd_digit_t d_i,
  input  logic       cin_i,
  output bcd_digit_t d_o,
  output logic       cout_o
);
  logic at_top;
  assign at_top = (d_i >= bcd_digit_t'(9));

  always_comb begin
    d_o    = d_i;
    cout_o = 1'b0;
    if (cin_i) begin
      if (at_top) begin
        d_o    = '0;
        cout_o = 1'b1;
      end else begin
        d_o = d_i + bcd_digit_t'(1);
      end
    end
  end
endmodule

// File: rtl/tod_us_counter.sv
module tod_us_counter
  import tod_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = US_DIGITS,
  localparam int unsigned W = NUM_DIGITS * DIGIT_W
) (
  input  logic [W-1:0] us_i,
  output logic [W-1:0] us_o
);
  // carry[k] enters digit k; digit 0 here is the least significant
  logic [NUM_DIGITS:0] carry;
  assign carry[0] = 1'b1;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    bcd_digit_inc u_inc (
      .d_i    (us_i[k*DIGIT_W +: DIGIT_W]),
      .cin_i  (carry[k]),
      .d_o    (us_o[k*DIGIT_W +: DIGIT_W]),
      .cout_o (carry[k+1])
    );
  end
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = US_DIGITS,
  localparam int unsigned W = NUM_DIGITS * DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] us_i,
  input  logic         ack_i,
  output logic         irq_o
);
  logic [W-1:0] alarm_q;
  logic         reached;
  logic         irq_q;

  // valid BCD orders the same as binary, so a plain magnitude compare suffices
  assign reached = (us_i >= alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   alarm_q <= '0;
    else if (ld_i) alarm_q <= val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                irq_q <= 1'b0;
    else if (ack_i)             irq_q <= 1'b0;
    else if (tick_i && reached) irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o); // R11
  AST_NO_RISE_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !tick_i) |=> !irq_o); // R11
  AST_ALARM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> alarm_q == $past(val_i)); // R9
endmodule

// File: rtl/tod_alarm_timer.sv
module tod_alarm_timer
  import tod_pkg::*;
#(
  parameter int unsigned NUM_DIGITS    = TOD_DIGITS,
  parameter int unsigned NUM_US_DIGITS = US_DIGITS,
  localparam int unsigned TW = NUM_DIGITS * DIGIT_W,
  localparam int unsigned UW = NUM_US_DIGITS * DIGIT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          set_i,
  input  logic [TW-1:0] set_val_i,
  output logic [TW-1:0] tod_o,
  input  logic          alarm_ld_i,
  input  logic [UW-1:0] alarm_val_i,
  output logic          alarm_irq_o,
  input  logic          alarm_ack_i
);
  logic [TW-1:0] tod_q;
  logic [UW-1:0] us_inc;

  tod_us_counter #(.NUM_DIGITS(NUM_US_DIGITS)) u_us (
    .us_i (tod_q[UW-1:0]),
    .us_o (us_inc)
  );

  // load beats the tick; calendar digits never advance in hardware
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tod_q <= '0;
    else if (set_i)  tod_q <= set_val_i;
    else if (tick_i) tod_q[UW-1:0] <= us_inc;
  end

  tod_alarm_unit #(.NUM_DIGITS(NUM_US_DIGITS)) u_alarm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .ld_i   (alarm_ld_i),
    .val_i  (alarm_val_i),
    .us_i   (tod_q[UW-1:0]),
    .ack_i  (alarm_ack_i),
    .irq_o  (alarm_irq_o)
  );

  assign tod_o = tod_q;

  AST_SET_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> tod_o == $past(set_val_i)); // R7
  AST_UPPER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> $stable(tod_o[TW-1:UW])); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !tick_i) |=> $stable(tod_o)); // R8
  AST_TICK_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && tick_i) |=> !$stable(tod_o[UW-1:0])); // R3
endmodule

// File: tb/tod_alarm_timer_test.sv
`timescale 1ns/1ps
module tod_alarm_timer_test;
  localparam int ND = 11;
  localparam longint unsigned MODV = 64'd100000000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, set = 1'b0, ald = 1'b0, ack = 1'b0;
  logic [79:0] set_val = '0;
  logic [43:0] alarm_val = '0;
  logic [79:0] tod;
  logic        irq;

  int n_run = 0, n_fail = 0;
  logic [79:0] exp_tod = '0;
  logic [43:0] exp_alarm = '0;
  logic        exp_irq = 1'b0;

  always #2.5 clk = ~clk;

  tod_alarm_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .set_i(set), .set_val_i(set_val),
    .tod_o(tod), .alarm_ld_i(ald), .alarm_val_i(alarm_val),
    .alarm_irq_o(irq), .alarm_ack_i(ack)
  );

  function automatic longint unsigned bcd2int(input logic [43:0] b);
    longint unsigned v = 0;
    for (int k = ND-1; k >= 0; k--) v = v*10 + longint'(b[k*4 +: 4]);
    return v;
  endfunction

  function automatic logic [43:0] int2bcd(input longint unsigned v);
    logic [43:0] b = '0;
    for (int k = 0; k < ND; k++) begin
      b[k*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return b;
  endfunction

  function automatic logic [35:0] rand_upper();
    logic [35:0] u;
    for (int k = 0; k < 9; k++) u[k*4 +: 4] = 4'($urandom % 10);
    return u;
  endfunction

  function automatic longint unsigned rand_us();
    longint unsigned r = {$urandom, $urandom};
    return r % MODV;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input string req, input logic t, input logic s, input logic [79:0] sv,
                     input logic al, input logic [43:0] av, input logic ak);
    longint unsigned us_old;
    tick = t; set = s; set_val = sv; ald = al; alarm_val = av; ack = ak;
    @(posedge clk);
    us_old = bcd2int(exp_tod[43:0]);
    if (ak) exp_irq = 1'b0;
    else if (t && us_old >= bcd2int(exp_alarm)) exp_irq = 1'b1;
    if (s) exp_tod = sv;
    else if (t) exp_tod[43:0] = int2bcd((us_old + 1) % MODV);
    if (al) exp_alarm = av;
    @(negedge clk);
    check(req, tod, exp_tod);
    check(req, {79'd0, irq}, {79'd0, exp_irq});
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", tod, '0);
    check("R1", {79'd0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", tod, '0);
    check("R1", {79'd0, irq}, '0);
    cyc("R1", 0, 0, '0, 0, '0, 1);

    // wrap and calendar isolation
    cyc("R2", 0, 1, {36'h202412310, int2bcd(64'd99999999998)}, 0, '0, 1);
    cyc("R3", 1, 0, '0, 0, '0, 1);
    cyc("R5", 1, 0, '0, 0, '0, 1);
    check("R6", {44'd0, tod[79:44]}, {44'd0, 36'h202412310});
    cyc("R3", 1, 0, '0, 0, '0, 1);

    // carry ripple through a run of nines
    cyc("R2", 0, 1, {36'h199901010, int2bcd(64'd99999)}, 0, '0, 1);
    cyc("R4", 1, 0, '0, 0, '0, 1);
    check("R4", {36'd0, tod[43:0]}, {36'd0, 44'h00000100000});

    // load and tick on the same edge
    cyc("R7", 1, 1, {36'h205006150, int2bcd(64'd12345)}, 0, '0, 1);
    check("R7", {36'd0, tod[43:0]}, {36'd0, 44'h00000012345});
    cyc("R8", 0, 0, '0, 0, '0, 0);
    cyc("R8", 0, 0, '0, 0, '0, 1);

    // alarm compare boundaries
    cyc("R9", 0, 1, {36'h200001010, int2bcd(64'd498)}, 1, int2bcd(64'd500), 1);
    cyc("R10", 1, 0, '0, 0, '0, 0);
    cyc("R10", 1, 0, '0, 0, '0, 0);
    check("R10", {79'd0, irq}, '0);
    cyc("R10", 1, 0, '0, 0, '0, 0);
    check("R10", {79'd0, irq}, {79'd0, 1'b1});
    cyc("R11", 0, 0, '0, 0, '0, 0);
    cyc("R11", 1, 0, '0, 0, '0, 1);
    check("R11", {79'd0, irq}, '0);
    cyc("R11", 1, 0, '0, 0, '0, 0);
    check("R11", {79'd0, irq}, {79'd0, 1'b1});

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic t, s, al, ak;
      logic [79:0] sv;
      logic [43:0] av;
      longint unsigned cur;
      t  = ($urandom % 10) < 7;
      s  = ($urandom % 40) == 0;
      al = ($urandom % 20) == 0;
      ak = ($urandom % 6) == 0;
      cur = bcd2int(exp_tod[43:0]);
      if ($urandom % 3 == 0) sv = {rand_upper(), int2bcd(MODV - 1 - longint'($urandom % 50))};
      else sv = {rand_upper(), int2bcd(rand_us())};
      av = int2bcd((cur + longint'($urandom % 20)) % MODV);
      cyc(s ? "R2" : (t ? "R3" : "R8"), t, s, sv, al, av, ak);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule